// File: doc/BRIEF.md
# Byte-wide configuration port receiver

This block is the device-side front end of a byte-wide slave configuration port. On each rising edge of the configuration clock it may take one byte from an 8-bit data bus. A byte is taken only when the chip-select and write strobes are both low and the receiver is not busy. The receiver packs the bytes into 32-bit words, most significant byte first. It forwards no word until it has found the synchronization pattern 0xAA995566 in the byte stream. The host may stop and restart a write by raising chip-select for any number of cycles. Byte packing carries on across these gaps.

The host aborts a write by raising the write strobe while chip-select stays low. The receiver then drops its word alignment and any partial word. It holds BUSY for a fixed number of cycles and goes back to hunting for the synchronization pattern. Aligned words leave on a valid/ready stream. A completed word stays on the output, unchanged, until the consumer accepts it. While a word is waiting and ready is low, BUSY is high, so the host holds back the next byte and nothing is lost. When ready stays high and no abort occurs, BUSY never rises and the host can write a byte on every clock.

Top module: `cfg_byte_rx`

## Requirements
- R1: A byte on `din` is accepted on a rising edge where `cs_n`=0, `wr_n`=0 and `busy`=0. Accepted bytes are packed most significant byte first, so the first byte of a word appears in `word_data[31:24]`.
- R2: On an edge where `cs_n`=1, the values of `wr_n` and `din` have no effect. The partial word and the alignment are kept, so a word may be split across separate chip-select periods.
- R3: While unaligned, the receiver compares the last four accepted bytes with 0xAA995566. When they match it becomes aligned. The synchronization word itself is not forwarded, and no word is forwarded before a match.
- R4: Once aligned, every fourth accepted byte completes a word that is forwarded. This includes words equal to 0xAA995566.
- R5: An edge with `cs_n`=0 and `wr_n`=1 is an abort. `busy` is high for exactly ABORT_CYCLES cycles after that edge (default 4).
- R6: An abort clears the alignment and the partial word. The next word is forwarded only after a fresh synchronization word.
- R7: A byte presented while `busy` is high is not accepted. It neither contributes to a word nor to a synchronization match.
- R8: `word_valid` stays high, with `word_data` unchanged, until a cycle in which `word_ready` is high. While `word_valid`=1 and `word_ready`=0, `busy` is high.
- R9: With `word_ready` held high and no abort, `busy` stays low and a byte can be accepted on every clock.
- R10: While `rst_n`=0, alignment and the partial word are cleared, `busy`=0 and `word_valid`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low chip select |
| wr_n | input | 1 | Active-low write strobe |
| din | input | 8 | Configuration byte |
| busy | output | 1 | Host must hold its byte while high |
| word_valid | output | 1 | A packed word is on `word_data` |
| word_ready | input | 1 | Consumer accepts the word this cycle |
| word_data | output | 32 | Packed word, first byte in bits 31:24 |

## Verification
A wrong alignment flag shows up at the ports within four accepted bytes. With a false alignment, words appear before a synchronization word. With a lost alignment, a word that should have arrived never does. A wrong byte counter or a shifted byte lane gives a word with its bytes rotated or replaced, so every expected word is compared in full. A byte wrongly taken while busy, or a dropped abort, changes the next word or its absence. A wrong abort counter shows as a `busy` pulse whose length differs from ABORT_CYCLES.

// File: rtl/cfg_rx_pkg.sv
package cfg_rx_pkg;
  localparam int unsigned BYTE_W_DEF  = 8;
  localparam int unsigned WORD_W_DEF  = 32;
  localparam logic [31:0] SYNC_PATTERN = 32'hAA995566;
endpackage

// File: rtl/cfg_rx_ctrl.sv
module cfg_rx_ctrl #(
  parameter int unsigned ABORT_CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic wr_n,
  input  logic stall,
  output logic take,
  output logic abort,
  output logic busy
);
  localparam int unsigned CW = $clog2(ABORT_CYCLES + 1);

  logic [CW-1:0] hold_cnt;

  assign abort = !cs_n && wr_n;
  assign busy  = (hold_cnt != '0) || stall;
  assign take  = !cs_n && !wr_n && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_cnt <= '0;
    end else if (abort) begin
      hold_cnt <= CW'(ABORT_CYCLES);
    end else if (hold_cnt != '0) begin
      hold_cnt <= hold_cnt - 1'b1;
    end
  end

  // R5: an abort edge is followed by busy
  a_r5_busy_after_abort: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> busy);

  // R10: reset leaves the port idle
  a_r10_reset_idle: assert property (@(posedge clk)
    !rst_n |-> !busy || stall);
endmodule

// File: rtl/cfg_rx_packer.sv
module cfg_rx_packer
  import cfg_rx_pkg::*;
#(
  parameter int unsigned BYTE_W = BYTE_W_DEF,
  parameter int unsigned WORD_W = WORD_W_DEF,
  parameter logic [WORD_W-1:0] SYNC = SYNC_PATTERN[WORD_W-1:0]
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              take,
  input  logic              abort,
  input  logic [BYTE_W-1:0] din,
  output logic              word_done,
  output logic [WORD_W-1:0] word
);
  localparam int unsigned LANES = WORD_W / BYTE_W;
  localparam int unsigned LW    = (LANES > 1) ? $clog2(LANES) : 1;
  localparam logic [LW-1:0] LAST = LW'(LANES - 1);

  logic [WORD_W-1:0] shreg;
  logic [WORD_W-1:0] nxt;
  logic              aligned;
  logic [LW-1:0]     lane;

  generate
    if (WORD_W > BYTE_W) begin : g_shift
      assign nxt = {shreg[WORD_W-BYTE_W-1:0], din};
    end else begin : g_direct
      assign nxt = din;
    end
  endgenerate

  assign word_done = take && aligned && (lane == LAST);
  assign word      = nxt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg   <= '0;
      aligned <= 1'b0;
      lane    <= '0;
    end else if (abort) begin
      shreg   <= '0;
      aligned <= 1'b0;
      lane    <= '0;
    end else if (take) begin
      shreg <= nxt;
      if (!aligned) begin
        if (nxt == SYNC) begin
          aligned <= 1'b1;
          lane    <= '0;
        end
      end else begin
        lane <= (lane == LAST) ? '0 : lane + 1'b1;
      end
    end
  end

  // R2: idle edges keep the packing state
  a_r2_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> $stable(shreg) && $stable(lane) && $stable(aligned));

  // R6: abort always drops alignment
  a_r6_abort_unaligns: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> !aligned && lane == '0);

  // R3: no word completes while hunting
  a_r3_no_word_unaligned: assert property (@(posedge clk) disable iff (!rst_n)
    !aligned |-> !word_done);

  // R7: nothing shifts without an accepted byte
  a_r7_no_take_no_shift: assert property (@(posedge clk) disable iff (!rst_n)
    !take && !abort |=> $stable(shreg));
endmodule

// File: rtl/cfg_rx_outreg.sv
module cfg_rx_outreg #(
  parameter int unsigned WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WORD_W-1:0] load_data,
  input  logic              ready,
  output logic              valid,
  output logic [WORD_W-1:0] data,
  output logic              stall
);
  assign stall = valid && !ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid <= 1'b0;
      data  <= '0;
    end else if (load) begin
      valid <= 1'b1;
      data  <= load_data;
    end else if (ready) begin
      valid <= 1'b0;
    end
  end

  // R8: a waiting word is held steady
  a_r8_hold_word: assert property (@(posedge clk) disable iff (!rst_n)
    valid && !ready |=> valid && $stable(data));

  // R8: no overwrite of an unaccepted word
  a_r8_no_overwrite: assert property (@(posedge clk) disable iff (!rst_n)
    valid && !ready |-> !load);
endmodule

// File: rtl/cfg_byte_rx.sv
module cfg_byte_rx
  import cfg_rx_pkg::*;
#(
  parameter int unsigned BYTE_W       = BYTE_W_DEF,
  parameter int unsigned WORD_W       = WORD_W_DEF,
  parameter int unsigned ABORT_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              wr_n,
  input  logic [BYTE_W-1:0] din,
  output logic              busy,
  output logic              word_valid,
  input  logic              word_ready,
  output logic [WORD_W-1:0] word_data
);
  logic              take;
  logic              abort;
  logic              stall;
  logic              word_done;
  logic [WORD_W-1:0] word;

  cfg_rx_ctrl #(.ABORT_CYCLES(ABORT_CYCLES)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_n(wr_n),
    .stall(stall), .take(take), .abort(abort), .busy(busy)
  );

  cfg_rx_packer #(.BYTE_W(BYTE_W), .WORD_W(WORD_W)) u_pack (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .take(take), .abort(abort),
    .din(din), .word_done(word_done), .word(word)
  );

  cfg_rx_outreg #(.WORD_W(WORD_W)) u_out (
    .clk(clk), .rst_n(rst_n), .load(word_done), .load_data(word),
    .ready(word_ready), .valid(word_valid), .data(word_data), .stall(stall)
  );

  // R9: without abort history and with ready high, busy stays low
  a_r9_no_busy_streaming: assert property (@(posedge clk) disable iff (!rst_n)
    word_ready && !$past(abort) && !busy && !abort |=> !busy);
endmodule

// File: tb/cfg_byte_rx_bench.sv
module cfg_byte_rx_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_n = 1'b1;
  logic        wr_n = 1'b1;
  logic [7:0]  din = '0;
  logic        busy;
  logic        word_valid;
  logic        word_ready = 1'b1;
  logic [31:0] word_data;

  int n_chk = 0;
  int n_bad = 0;
  int cap_n = 0;
  logic [31:0] cap [16];
  bit done = 0;

  always #4 clk = ~clk;

  cfg_byte_rx u_cfg_byte_rx (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_n(wr_n), .din(din),
    .busy(busy), .word_valid(word_valid), .word_ready(word_ready),
    .word_data(word_data)
  );

  always @(negedge clk) begin
    #1;
    if (rst_n && word_valid && word_ready) begin
      if (cap_n < 16) cap[cap_n] = word_data;
      cap_n++;
    end
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] b);
    @(negedge clk); cs_n = 1'b0; wr_n = 1'b0; din = b;
  endtask

  task automatic send_word(input logic [31:0] w);
    for (int i = 3; i >= 0; i--) send(w[i*8 +: 8]);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); cs_n = 1'b1; wr_n = 1'b1;
    end
  endtask

  task automatic do_abort();
    @(negedge clk); cs_n = 1'b0; wr_n = 1'b1;
    @(negedge clk); cs_n = 1'b1;
  endtask

  task automatic wait_quiet();
    idle(1);
    while (busy) idle(1);
    idle(1);
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; cs_n = 1'b1; wr_n = 1'b1;
    idle(2);
    #1;
    check(busy == 1'b0 && word_valid == 1'b0, "R10 idle in reset",
          {30'b0, busy, word_valid}, 32'h0);
    @(negedge clk); rst_n = 1'b1;
    idle(1);
  endtask

  task automatic t_reset_state();
    do_reset();
    check(cap_n == 0, "R10 no word after reset", cap_n, 0);
  endtask

  task automatic t_hunt();
    int base = cap_n;
    send_word(32'h11223344); send_word(32'hAA995500);
    wait_quiet();
    check(cap_n == base, "R3 nothing before sync", cap_n - base, 0);
    send_word(32'hAA995566); send_word(32'hDEADBEEF);
    wait_quiet();
    check(cap_n == base + 1, "R3 one word after sync", cap_n - base, 1);
    check(cap[base] == 32'hDEADBEEF, "R1 msb-first packing", cap[base], 32'hDEADBEEF);
  endtask

  task automatic t_gaps();
    int base = cap_n;
    send(8'hA1); idle(3);
    @(negedge clk); cs_n = 1'b1; wr_n = 1'b0; din = 8'h5A;
    @(negedge clk); cs_n = 1'b1; wr_n = 1'b1; din = 8'hC3;
    send(8'hB2); send(8'hC3); idle(2); send(8'hD4);
    wait_quiet();
    check(cap_n == base + 1, "R2 word across gaps count", cap_n - base, 1);
    check(cap[base] == 32'hA1B2C3D4, "R2 word across gaps data", cap[base], 32'hA1B2C3D4);
  endtask

  task automatic t_sync_as_data();
    int base = cap_n;
    send_word(32'hAA995566); send_word(32'h01020304);
    wait_quiet();
    check(cap_n == base + 2, "R4 sync pattern forwarded count", cap_n - base, 2);
    check(cap[base] == 32'hAA995566, "R4 sync pattern forwarded data", cap[base], 32'hAA995566);
    check(cap[base+1] == 32'h01020304, "R4 following word", cap[base+1], 32'h01020304);
  endtask

  task automatic t_abort();
    int base = cap_n;
    int hi = 0;
    send(8'h12); send(8'h34);
    @(negedge clk); cs_n = 1'b0; wr_n = 1'b1;
    @(negedge clk); cs_n = 1'b1; wr_n = 1'b1;
    #1;
    while (busy && hi < 50) begin
      hi++;
      @(negedge clk); #1;
    end
    check(hi == 4, "R5 busy length after abort", hi, 4);
    send_word(32'h56789ABC);
    wait_quiet();
    check(cap_n == base, "R6 unaligned after abort", cap_n - base, 0);
    send_word(32'hAA995566); send_word(32'hCAFEF00D);
    wait_quiet();
    check(cap_n == base + 1 && cap[base] == 32'hCAFEF00D, "R6 resync after abort",
          cap[base], 32'hCAFEF00D);
  endtask

  task automatic t_busy_ignore();
    int base = cap_n;
    do_abort();
    send(8'hAA); send(8'h99);
    wait_quiet();
    send(8'h55); send(8'h66); send_word(32'hDEADBEEF);
    wait_quiet();
    check(cap_n == base, "R7 bytes during busy ignored", cap_n - base, 0);
    send_word(32'hAA995566); send_word(32'h0BADC0DE);
    wait_quiet();
    check(cap_n == base + 1 && cap[base] == 32'h0BADC0DE, "R7 recover", cap[base], 32'h0BADC0DE);
  endtask

  task automatic t_backpressure();
    int base = cap_n;
    @(negedge clk); word_ready = 1'b0;
    send_word(32'h13579BDF);
    idle(1); #1;
    check(word_valid && busy, "R8 stalled word raises busy", {30'b0, word_valid, busy}, 32'h3);
    send(8'h77);
    idle(2); #1;
    check(word_valid && word_data == 32'h13579BDF, "R8 word held", word_data, 32'h13579BDF);
    @(negedge clk); cs_n = 1'b1; word_ready = 1'b1;
    idle(2); #1;
    check(!busy && cap_n == base + 1 && cap[base] == 32'h13579BDF, "R8 word taken",
          cap[base], 32'h13579BDF);
    send_word(32'h8899AABB);
    wait_quiet();
    check(cap_n == base + 2 && cap[base+1] == 32'h8899AABB, "R7 byte under stall dropped",
          cap[base+1], 32'h8899AABB);
  endtask

  task automatic t_stream();
    int base = cap_n;
    int seen_busy = 0;
    for (int w = 0; w < 3; w++) begin
      for (int i = 3; i >= 0; i--) begin
        send(8'(w * 16 + i));
        #1; if (busy) seen_busy++;
      end
    end
    wait_quiet();
    check(seen_busy == 0, "R9 busy stays low", seen_busy, 0);
    check(cap_n == base + 3 && cap[base+2] == 32'h23222120, "R9 back-to-back words",
          cap[base+2], 32'h23222120);
  endtask

  task automatic t_reset_mid();
    int base = cap_n;
    send(8'hFE); send(8'hED);
    do_reset();
    send_word(32'h01234567);
    wait_quiet();
    check(cap_n == base, "R10 reset drops alignment", cap_n - base, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    t_reset_state();
    t_hunt();
    t_gaps();
    t_sync_as_data();
    t_abort();
    t_busy_ignore();
    t_backpressure();
    t_stream();
    t_reset_mid();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule